// File: doc/BRIEF.md
# Interrupt-Driven Serial ADC Reader

This block is the host-side controller for a single successive-approximation converter wired in three-wire select mode with a busy indicator. A start request raises the convert/select line, which begins a conversion inside the converter. After a fixed number of cycles the controller drops the line again, well inside the converter's minimum conversion time. While the conversion runs, the converter's data output is released and reads high through the board pull-up.

When the converter finishes, it drives its data line low. The controller watches for that high-to-low transition and treats it as the end-of-conversion interrupt. It then generates 18 serial clock pulses and shifts the result in, most significant bit first. Once the last bit is in, it updates the result bus together with a one-cycle valid strobe.

If no busy edge arrives within a bounded time after the longest possible conversion, the controller raises a one-cycle error pulse and returns to idle. All timing is counted in system clock cycles and set through parameters. The controller ignores start requests while a conversion or readout is in progress.

Top module: `serial_adc_reader`

## Requirements
- R1: A start request accepted in idle drives `cnv_o` high on the next clock edge. It stays high for exactly `CNV_HIGH_CYC` cycles and then goes low. `CNV_HIGH_CYC` is configured below `T_CONV_MIN_CYC`.
- R2: After each rise of `cnv_o`, the line stays low until more than `T_CONV_MAX_CYC` cycles have passed since that rise. Only then can it rise again.
- R3: While waiting with `cnv_o` low, a high-to-low transition of `sdo_i` between two consecutive clock samples is taken as end of conversion. The readout starts on that same edge.
- R4: The readout makes exactly 18 `sclk_o` pulses. Each pulse is high for `SCLK_HALF_CYC` cycles and then low for `SCLK_HALF_CYC` cycles, and the first pulse rises on the detection edge. `sclk_o` is low at all other times.
- R5: `sdo_i` is sampled on the last cycle of each low phase, which is the sample taken when the next rise would occur. The first sample becomes `result_o[17]` and the 18th becomes `result_o[0]`.
- R6: `valid_o` is high for one cycle on the edge that captures the 18th bit. `result_o` changes only in that cycle and holds its value otherwise.
- R7: Suppose no busy edge is seen within `T_CONV_MAX_CYC + TIMEOUT_CYC` edges of the accepting edge. Then `err_o` pulses for one cycle on that edge, the controller returns to idle, and no serial clock or valid strobe is produced.
- R8: Start requests are ignored unless the controller is idle. Holding `start_i` high produces back-to-back conversions, each fully read out.
- R9: While `rst_ni` is low, `cnv_o`, `sclk_o`, `valid_o` and `err_o` are low and `result_o` is zero.
- R10: `sclk_o` is never high while `cnv_o` is high, and `valid_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| cnv_o | output | 1 | Convert / chip-select line to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Converter data line (pulled up), synchronous to clk_i |
| result_o | output | 18 | Last captured conversion result |
| valid_o | output | 1 | One-cycle strobe when result_o updates |
| err_o | output | 1 | One-cycle pulse on end-of-conversion timeout |

## Verification
Several behaviours are checked by assertions on every cycle. These are the convert pulse width, the minimum spacing between convert rises, the serial clock high-phase length, and the pulse count at the valid strobe. The assertions also check that the result holds between strobes, that no start is accepted while busy, and that the two exclusion rules hold. The exact cycle of each edge, the bit order against the word the converter model holds, timeout recovery and back-to-back conversions under a held start can only be shown by the bench's scenarios. There, a behavioural converter model and a reference timeline are compared against the ports on every clock.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV_HI,
    ST_WAIT,
    ST_SHIFT,
    ST_HOLD
  } rd_state_e;
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int unsigned LIMIT = 56,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_o <= W'(LIMIT);
    else if (clear_i) count_o <= '0;
    else if (count_o != W'(LIMIT)) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/adc_rd_fall_det.sv
module adc_rd_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic fall_o
);
  logic d_q;
  // line idles high through the pull-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b1;
    else d_q <= d_i;
  end
  assign fall_o = d_q & ~d_i;
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int unsigned NBITS = 18,
  parameter int unsigned HALF  = 2,
  localparam int unsigned PW = $clog2(HALF + 1),
  localparam int unsigned BW = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             sdo_i,
  output logic             sclk_o,
  output logic             done_o,
  output logic [NBITS-1:0] word_o
);
  logic             active_q, sclk_q, done_q;
  logic [PW-1:0]    ph_q;
  logic [BW-1:0]    bit_q;
  logic [NBITS-1:0] sr_q, word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      ph_q     <= '0;
      bit_q    <= '0;
      sr_q     <= '0;
      word_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b1;
        ph_q     <= '0;
        bit_q    <= '0;
      end else if (active_q) begin
        if (ph_q == PW'(HALF - 1)) begin
          ph_q <= '0;
          if (sclk_q) begin
            sclk_q <= 1'b0;
          end else begin
            // end of low phase: data settled after the preceding fall
            sr_q <= {sr_q[NBITS-2:0], sdo_i};
            if (bit_q == BW'(NBITS - 1)) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
              word_q   <= {sr_q[NBITS-2:0], sdo_i};
            end else begin
              bit_q  <= bit_q + 1'b1;
              sclk_q <= 1'b1;
            end
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign done_o = done_q;
  assign word_o = word_q;

  // observation counters for assertions
  logic          sclk_d;
  logic [BW-1:0] rises_q;
  logic [PW-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rises_q  <= '0;
      hi_run_q <= '0;
    end else begin
      sclk_d <= sclk_q;
      if (done_q) rises_q <= '0;
      else if (sclk_q && !sclk_d && rises_q != BW'(NBITS)) rises_q <= rises_q + 1'b1;
      if (!sclk_q) hi_run_q <= '0;
      else if (hi_run_q != PW'(HALF)) hi_run_q <= hi_run_q + 1'b1;
    end
  end

  a_r4_high_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> hi_run_q < PW'(HALF));
  a_r4_pulse_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> rises_q == BW'(NBITS));
  a_r6_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $stable(word_q));
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader #(
  parameter int unsigned RES_BITS       = 18,
  parameter int unsigned CNV_HIGH_CYC   = 4,
  parameter int unsigned T_CONV_MIN_CYC = 20,
  parameter int unsigned T_CONV_MAX_CYC = 40,
  parameter int unsigned TIMEOUT_CYC    = 16,
  parameter int unsigned SCLK_HALF_CYC  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  output logic                cnv_o,
  output logic                sclk_o,
  input  logic                sdo_i,
  output logic [RES_BITS-1:0] result_o,
  output logic                valid_o,
  output logic                err_o
);
  import adc_rd_pkg::*;

  localparam int unsigned LIMIT = T_CONV_MAX_CYC + TIMEOUT_CYC;
  localparam int unsigned TW    = $clog2(LIMIT + 1);
  localparam int unsigned CW    = $clog2(CNV_HIGH_CYC + 1);
  localparam int unsigned GW    = $clog2(T_CONV_MAX_CYC + 1);

  rd_state_e     state_q;
  logic          cnv_q, err_q;
  logic [TW-1:0] tmr;
  logic          fall, go, clear, done;

  assign clear = (state_q == ST_IDLE) && start_i;
  assign go    = (state_q == ST_WAIT) && fall;

  adc_rd_timer #(.LIMIT(LIMIT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .count_o (tmr)
  );

  adc_rd_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sdo_i),
    .fall_o (fall)
  );

  adc_rd_shifter #(.NBITS(RES_BITS), .HALF(SCLK_HALF_CYC)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .sdo_i  (sdo_i),
    .sclk_o (sclk_o),
    .done_o (done),
    .word_o (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnv_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CNV_HI;
          cnv_q   <= 1'b1;
        end
        ST_CNV_HI: if (tmr == TW'(CNV_HIGH_CYC - 1)) begin
          cnv_q   <= 1'b0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fall) state_q <= ST_SHIFT;
          else if (tmr == TW'(LIMIT - 1)) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_SHIFT: if (done) state_q <= ST_HOLD;
        // keep select low past the longest conversion
        ST_HOLD: if (tmr >= TW'(T_CONV_MAX_CYC)) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_o   = cnv_q;
  assign err_o   = err_q;
  assign valid_o = done;

  // observation counters for assertions
  logic          cnv_d;
  logic [CW-1:0] cnv_run_q;
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnv_d     <= 1'b0;
      cnv_run_q <= '0;
      gap_q     <= GW'(T_CONV_MAX_CYC);
    end else begin
      cnv_d <= cnv_q;
      if (!cnv_q) cnv_run_q <= '0;
      else if (cnv_run_q != CW'(CNV_HIGH_CYC)) cnv_run_q <= cnv_run_q + 1'b1;
      if (cnv_q && !cnv_d) gap_q <= '0;
      else if (gap_q != GW'(T_CONV_MAX_CYC)) gap_q <= gap_q + 1'b1;
    end
  end

  a_r1_cnv_not_long: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_q |-> cnv_run_q < CW'(CNV_HIGH_CYC));
  a_r1_cnv_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_q) |-> cnv_run_q == CW'(CNV_HIGH_CYC));
  a_r2_rise_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cnv_q) |-> gap_q >= GW'(T_CONV_MAX_CYC));
  a_r8_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !$rose(cnv_q));
  a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (!sclk_o && !cnv_q));
  a_r10_sclk_vs_cnv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_o && cnv_q));
  a_r10_valid_vs_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done && err_q));
endmodule

// File: tb/serial_adc_reader_test.sv
`timescale 1ns / 100ps
module serial_adc_reader_test;
  localparam int NB    = 18;
  localparam int CH    = 4;
  localparam int TMIN  = 20;
  localparam int TMAX  = 40;
  localparam int TOUT  = 16;
  localparam int H     = 2;
  localparam int LIM   = TMAX + TOUT;
  localparam int XFER  = 2 * NB * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sdo = 1'b1;
  logic cnv_o, sclk_o, valid_o, err_o;
  logic [NB-1:0] result_o;

  always #2.5 clk = ~clk;

  serial_adc_reader #(
    .RES_BITS(NB), .CNV_HIGH_CYC(CH), .T_CONV_MIN_CYC(TMIN),
    .T_CONV_MAX_CYC(TMAX), .TIMEOUT_CYC(TOUT), .SCLK_HALF_CYC(H)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cnv_o(cnv_o),
    .sclk_o(sclk_o), .sdo_i(sdo), .result_o(result_o),
    .valid_o(valid_o), .err_o(err_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model: releases on select rise, busy-low after dev_conv cycles, bit per sclk fall
  logic [NB-1:0] dev_word = '0;
  int  dev_conv = 25;
  bit  dev_silent = 0;
  int  dev_st = 0;
  int  dev_cnt = 0;
  int  dev_bits = 0;
  logic dev_cnv_p = 1'b0;
  logic dev_sclk_p = 1'b0;
  always @(posedge clk) begin
    #1;
    if (cnv_o && !dev_cnv_p) begin
      dev_st = 1; dev_cnt = 0; sdo = 1'b1;
    end else if (dev_st == 1) begin
      dev_cnt++;
      if (dev_cnt >= dev_conv && !cnv_o && !dev_silent) begin
        sdo = 1'b0; dev_st = 2; dev_bits = 0;
      end
    end else if (dev_st == 2 && dev_sclk_p && !sclk_o) begin
      if (dev_bits < NB) begin
        sdo = dev_word[NB-1-dev_bits];
        dev_bits++;
      end else begin
        sdo = 1'b1; dev_st = 0;
      end
    end
    dev_cnv_p  = cnv_o;
    dev_sclk_p = sclk_o;
  end

  // reference timeline
  logic exp_cnv = 0, exp_sclk = 0, exp_valid = 0, exp_err = 0;
  logic [NB-1:0] exp_res = '0;
  logic [NB-1:0] m_sr = '0;
  bit m_act = 0;
  int m_age = 0;
  int m_busy = -1;
  logic m_prev = 1'b1;
  always @(posedge clk or negedge rst_n) begin : ref_model
    int j;
    logic s, f;
    if (!rst_n) begin
      m_act = 0; m_prev = 1'b1; exp_cnv = 0; exp_sclk = 0;
      exp_valid = 0; exp_err = 0; exp_res = '0;
    end else begin
      s = sdo;
      f = m_prev && !s;
      m_prev = s;
      exp_valid = 0;
      exp_err = 0;
      if (!m_act) begin
        if (start) begin m_act = 1; m_age = 0; m_busy = -1; end
      end else begin
        m_age++;
        if (m_busy < 0) begin
          if (m_age >= CH + 1 && f) m_busy = m_age;
          else if (m_age == LIM) begin exp_err = 1; m_act = 0; end
        end else begin
          j = m_age - m_busy;
          if (j <= XFER && j % (2 * H) == 0) m_sr = {m_sr[NB-2:0], s};
          if (j == XFER) begin exp_valid = 1; exp_res = m_sr; end
          if (j >= XFER + 2 && m_age - 1 >= TMAX) m_act = 0;
        end
      end
      exp_cnv  = m_act && m_busy < 0 && m_age < CH;
      exp_sclk = m_act && m_busy >= 0 && (m_age - m_busy) < XFER && ((m_age - m_busy) % (2 * H)) < H;
    end
  end

  bit cmp_en = 0;
  int v_cnt = 0, e_cnt = 0, rise_cnt = 0;
  logic cnv_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(cnv_o === exp_cnv, "R1/R2/R8 cnv_o", cnv_o, exp_cnv);
      chk(sclk_o === exp_sclk, "R3/R4 sclk_o", sclk_o, exp_sclk);
      chk(valid_o === exp_valid, "R6 valid_o", valid_o, exp_valid);
      chk(err_o === exp_err, "R7 err_o", err_o, exp_err);
      chk(result_o === exp_res, "R5/R6 result_o", result_o, exp_res);
      chk(!(sclk_o && cnv_o) && !(valid_o && err_o), "R10 exclusion", {sclk_o, cnv_o, valid_o, err_o}, 0);
      if (valid_o) chk(result_o === dev_word, "R5 result_o vs converter word", result_o, dev_word);
      if (valid_o) v_cnt++;
      if (err_o) e_cnt++;
      if (cnv_o && !cnv_seen) rise_cnt++;
      cnv_seen = cnv_o;
    end
  end

  task automatic run_one(input logic [NB-1:0] w, input int conv, input bit silent);
    int v0, e0;
    v0 = v_cnt; e0 = e_cnt;
    dev_word = w; dev_conv = conv; dev_silent = silent;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (200) @(negedge clk);
    if (silent) begin
      chk(e_cnt == e0 + 1, "R7 timeout flagged", e_cnt - e0, 1);
      chk(v_cnt == v0, "R7 no valid after timeout", v_cnt - v0, 0);
    end else begin
      chk(v_cnt == v0 + 1, "R3 busy edge started readout", v_cnt - v0, 1);
      chk(e_cnt == e0, "R7 no false timeout", e_cnt - e0, 0);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    int r0, v0;
    repeat (3) @(negedge clk);
    chk({cnv_o, sclk_o, valid_o, err_o} === 4'b0, "R9 control outputs in reset", {cnv_o, sclk_o, valid_o, err_o}, 0);
    chk(result_o === '0, "R9 result_o in reset", result_o, 0);
    @(negedge clk) rst_n = 1'b1;
    cmp_en = 1;
    repeat (5) @(negedge clk);
    run_one(18'h2A5C3, 25, 0);
    run_one(18'h3FFFF, 21, 0);
    run_one(18'h00000, 40, 0);
    run_one(18'h12345, 30, 1);
    run_one(18'h15555, 23, 0);
    run_one(18'h20001, 25, 0);
    // R8: start held high across whole transfers
    dev_word = 18'h0F0F0; dev_conv = 25; dev_silent = 0;
    r0 = rise_cnt; v0 = v_cnt;
    @(negedge clk) start = 1'b1;
    repeat (400) @(negedge clk);
    start = 1'b0;
    repeat (200) @(negedge clk);
    chk(rise_cnt - r0 >= 3, "R8 back-to-back conversions", rise_cnt - r0, 3);
    chk(v_cnt - v0 == rise_cnt - r0, "R8 each conversion read out", v_cnt - v0, rise_cnt - r0);
    finish_run();
  end
endmodule